// File: doc/BRIEF.md
# Adaptive Work-List Lookahead Controller

This controller sits beside a graph-traversal prefetch engine. It decides how far ahead in the breadth-first work list the engine should prefetch. It also decides whether the engine may prefetch work-list entries at all.

Three running averages are kept. The first is the cache fill latency. The second is the cycle gap between consecutive vertex starts, which is the per-vertex processing time. The third is the cycle gap between consecutive edges of one vertex. From these averages a lookahead offset is derived.

The controller runs a three-state machine:

- `ST_LOOKAHEAD` is the normal state. Prefetching is allowed at the computed offset.
- `ST_HOLD` is entered when a newly started vertex has a long edge list. In this state further work-list prefetches are blocked, so the engine spends its effort on the current vertex only.
- `ST_RELEASE` is entered when the work left on the current edge list fits inside one fill latency. The next work-list entry (offset 1) is then released.

The transitions are as follows:

- A vertex start moves the machine from any state to either `ST_HOLD` (large vertex) or `ST_LOOKAHEAD` (small vertex).
- `ST_HOLD` moves to `ST_RELEASE` when the tail test succeeds.

The averages are loaded from seed inputs while reset is held.

Top module: `pf_distance_ctrl`

## Requirements
- R1: While `rst_n` is low, the three averages load `seed_lat`, `seed_cpe` and `seed_vtx`, and the machine enters `ST_LOOKAHEAD`. After reset, `wl_pf_en` is 1 and `wl_offset` is computed from the seeds.
- R2: Each cycle with `fill_valid` high updates the latency average by avg ← avg + (sample − avg)/8. The division truncates the magnitude toward zero, so the average always moves toward the sample and never past it.
- R3: In `ST_LOOKAHEAD`, `wl_offset` is the smallest k in 1..16 with k·vtx_avg ≥ lat_avg, or 16 if no such k exists. The result is then raised to at least 2.
- R4: On each `vtx_start` after the first one since reset, the vertex-time average takes one update step (same rule as R2). The sample is the number of cycles since the previous `vtx_start`. The gap counters saturate at all-ones.
- R5: On each `edge_step`, the edge-time average takes one update step. The sample is the number of cycles since the previous `edge_step`. The first `edge_step` after a `vtx_start` gives no sample. An `edge_step` in the same cycle as `vtx_start` is ignored.
- R6: A `vtx_start` with `vtx_edges`·cpe_avg > lat_avg moves the machine to `ST_HOLD` on the next cycle. In `ST_HOLD`, `wl_pf_en` is 0 and `wl_offset` is 1.
- R7: In `ST_HOLD`, each `edge_step` decrements the remaining-edge count, stopping at 0. Once remaining·cpe_avg ≤ lat_avg, the next cycle moves the machine to `ST_RELEASE`, where `wl_pf_en` is 1 and `wl_offset` is 1.
- R8: A `vtx_start` with `vtx_edges`·cpe_avg ≤ lat_avg returns the machine to `ST_LOOKAHEAD` from any state. This includes `vtx_edges` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; averages load their seeds |
| seed_lat | input | LW | Initial fill latency average |
| seed_cpe | input | LW | Initial cycles-per-edge average |
| seed_vtx | input | LW | Initial per-vertex cycle average |
| vtx_start | input | 1 | Core reads the next work-list vertex |
| vtx_edges | input | EW | Out-degree of the vertex now starting |
| edge_step | input | 1 | Core finished one edge of the current vertex |
| fill_valid | input | 1 | A fill latency sample is present |
| fill_cycles | input | LW | Fill latency in cycles |
| wl_offset | output | OW | Work-list lookahead distance |
| wl_pf_en | output | 1 | Work-list prefetch permitted |

## Verification
Every input event is captured at the next rising edge, and both outputs are decoded from registered state. A stimulus applied before edge N is therefore visible in `wl_offset` and `wl_pf_en` from just after edge N.

The hold-to-release step is the exception. It takes one further edge, because the tail test reads the already decremented remaining count.

The bench drives inputs on falling edges and compares the outputs on the following falling edge. The comparison is made against a cycle model of the requirements that runs on the same rising edges. Every cycle of a long edge-list walk is therefore compared, not only its end points.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    typedef enum logic [1:0] {
        ST_LOOKAHEAD = 2'd0,
        ST_HOLD      = 2'd1,
        ST_RELEASE   = 2'd2
    } pdc_state_e;
endpackage

// File: rtl/pdc_ewma.sv
module pdc_ewma #(
    parameter int W     = 16,
    parameter int SHIFT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] seed,
    input  logic         upd,
    input  logic [W-1:0] sample,
    output logic [W-1:0] avg
);
    logic         up;
    logic [W-1:0] diff;
    logic [W-1:0] nxt;

    always_comb begin
        up   = (sample >= avg);
        diff = up ? (sample - avg) : (avg - sample);
        nxt  = up ? (avg + (diff >> SHIFT)) : (avg - (diff >> SHIFT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   avg <= seed;
        else if (upd) avg <= nxt;
    end

    // R2: average moves toward the sample, never beyond it
    a_r2_toward_up: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && sample >= avg) |=> (avg >= $past(avg) && avg <= $past(sample)));
    a_r2_toward_down: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && sample < avg) |=> (avg <= $past(avg) && avg >= $past(sample)));
endmodule

// File: rtl/pdc_gap_timer.sv
module pdc_gap_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         clear,
    output logic         smp_valid,
    output logic [W-1:0] smp
);
    logic [W-1:0] cnt;
    logic         have;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            have <= 1'b0;
        end else if (clear) begin
            have <= 1'b0;
        end else if (restart) begin
            cnt  <= W'(1);
            have <= 1'b1;
        end else if (cnt != '1) begin
            cnt <= cnt + W'(1);
        end
    end

    assign smp_valid = restart && have && !clear;
    assign smp       = cnt;

    // R4: the gap counter holds at all-ones until restarted
    a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1 && !restart && !clear) |=> (cnt == '1));
endmodule

// File: rtl/pdc_offset_calc.sv
module pdc_offset_calc #(
    parameter int LW         = 16,
    parameter int MAX_OFFSET = 16,
    parameter int OW         = 5
) (
    input  logic [LW-1:0] lat_avg,
    input  logic [LW-1:0] vtx_avg,
    output logic [OW-1:0] raw_off
);
    localparam int PW = LW + OW;

    logic [MAX_OFFSET:1] covers;

    for (genvar k = 1; k <= MAX_OFFSET; k++) begin : g_cmp
        assign covers[k] = (PW'(k) * PW'(vtx_avg)) >= PW'(lat_avg);
    end

    always_comb begin
        raw_off = OW'(MAX_OFFSET);
        for (int k = MAX_OFFSET; k >= 1; k--) begin
            if (covers[k]) raw_off = OW'(k);
        end
    end
endmodule

// File: rtl/pf_distance_ctrl.sv
module pf_distance_ctrl
    import pdc_pkg::*;
#(
    parameter int LW         = 16,
    parameter int EW         = 16,
    parameter int MAX_OFFSET = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [LW-1:0]                      seed_lat,
    input  logic [LW-1:0]                      seed_cpe,
    input  logic [LW-1:0]                      seed_vtx,
    input  logic                               vtx_start,
    input  logic [EW-1:0]                      vtx_edges,
    input  logic                               edge_step,
    input  logic                               fill_valid,
    input  logic [LW-1:0]                      fill_cycles,
    output logic [$clog2(MAX_OFFSET+1)-1:0]    wl_offset,
    output logic                               wl_pf_en
);
    localparam int OW = $clog2(MAX_OFFSET + 1);
    localparam int PW = EW + LW;

    logic [LW-1:0] lat_avg, cpe_avg, vtx_avg;
    logic          vtx_smp_v, edge_smp_v;
    logic [LW-1:0] vtx_smp, edge_smp;
    logic [OW-1:0] raw_off;
    logic [EW-1:0] rem_q;
    logic [PW-1:0] work_w, tail_w, lat_w;
    logic          big_vtx, tail_ok;
    pdc_state_e    state_q, state_d;

    // gap timers feeding the averages
    pdc_gap_timer #(.W(LW)) u_vtx_gap (
        .clk(clk), .rst_n(rst_n), .restart(vtx_start), .clear(1'b0),
        .smp_valid(vtx_smp_v), .smp(vtx_smp));

    pdc_gap_timer #(.W(LW)) u_edge_gap (
        .clk(clk), .rst_n(rst_n), .restart(edge_step), .clear(vtx_start),
        .smp_valid(edge_smp_v), .smp(edge_smp));

    pdc_ewma #(.W(LW), .SHIFT(3)) u_lat (
        .clk(clk), .rst_n(rst_n), .seed(seed_lat),
        .upd(fill_valid), .sample(fill_cycles), .avg(lat_avg));

    pdc_ewma #(.W(LW), .SHIFT(3)) u_cpe (
        .clk(clk), .rst_n(rst_n), .seed(seed_cpe),
        .upd(edge_smp_v), .sample(edge_smp), .avg(cpe_avg));

    pdc_ewma #(.W(LW), .SHIFT(3)) u_vtx (
        .clk(clk), .rst_n(rst_n), .seed(seed_vtx),
        .upd(vtx_smp_v), .sample(vtx_smp), .avg(vtx_avg));

    pdc_offset_calc #(.LW(LW), .MAX_OFFSET(MAX_OFFSET), .OW(OW)) u_off (
        .lat_avg(lat_avg), .vtx_avg(vtx_avg), .raw_off(raw_off));

    // work estimates against the fill latency
    always_comb begin
        lat_w   = PW'(lat_avg);
        work_w  = PW'(vtx_edges) * PW'(cpe_avg);
        tail_w  = PW'(rem_q) * PW'(cpe_avg);
        big_vtx = work_w > lat_w;
        tail_ok = tail_w <= lat_w;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKAHEAD: begin
                if (vtx_start && big_vtx) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (vtx_start)    state_d = big_vtx ? ST_HOLD : ST_LOOKAHEAD;
                else if (tail_ok) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (vtx_start)    state_d = big_vtx ? ST_HOLD : ST_LOOKAHEAD;
            end
            default: state_d = ST_LOOKAHEAD;
        endcase
    end

    // state register and remaining-edge count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOOKAHEAD;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            if (vtx_start)                   rem_q <= vtx_edges;
            else if (edge_step && rem_q != 0) rem_q <= rem_q - EW'(1);
        end
    end

    // outputs
    always_comb begin
        wl_pf_en  = 1'b1;
        wl_offset = OW'(1);
        unique case (state_q)
            ST_LOOKAHEAD: begin
                wl_pf_en  = 1'b1;
                wl_offset = (raw_off < OW'(2)) ? OW'(2) : raw_off;
            end
            ST_HOLD: begin
                wl_pf_en  = 1'b0;
                wl_offset = OW'(1);
            end
            ST_RELEASE: begin
                wl_pf_en  = 1'b1;
                wl_offset = OW'(1);
            end
            default: begin
                wl_pf_en  = 1'b1;
                wl_offset = OW'(2);
            end
        endcase
    end

    // R6: a large vertex blocks work-list prefetch on the next cycle
    a_r6_enter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (vtx_start && big_vtx) |=> (!wl_pf_en && wl_offset == OW'(1)));
    // R8: a small vertex restores lookahead with an offset of at least 2
    a_r8_small_vertex: assert property (@(posedge clk) disable iff (!rst_n)
        (vtx_start && !big_vtx) |=> (wl_pf_en && wl_offset >= OW'(2)));
    // R7: release once the tail fits inside one fill latency
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !vtx_start && tail_ok) |=> (wl_pf_en && wl_offset == OW'(1)));
    // R7: stay blocked while the tail is still too long
    a_r7_keep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !vtx_start && !tail_ok) |=> !wl_pf_en);
endmodule

// File: tb/sim_pf_distance_ctrl.sv
module sim_pf_distance_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LW   = 16;
    localparam int EW   = 16;
    localparam int MAXO = 16;
    localparam int OW   = $clog2(MAXO + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] seed_lat = 16'd200, seed_cpe = 16'd10, seed_vtx = 16'd40;
    logic          vtx_start = 1'b0, edge_step = 1'b0, fill_valid = 1'b0;
    logic [EW-1:0] vtx_edges = '0;
    logic [LW-1:0] fill_cycles = '0;
    logic [OW-1:0] wl_offset;
    logic          wl_pf_en;

    int n_checks = 0, n_fail = 0, cyc = 0;
    // reference model state (0 lookahead, 1 hold, 2 release)
    int m_lat, m_cpe, m_vtx, m_mode, m_rem, v_cnt, e_cnt;
    bit v_have, e_have;

    pf_distance_ctrl #(.LW(LW), .EW(EW), .MAX_OFFSET(MAXO)) u0 (
        .clk(clk), .rst_n(rst_n), .seed_lat(seed_lat), .seed_cpe(seed_cpe),
        .seed_vtx(seed_vtx), .vtx_start(vtx_start), .vtx_edges(vtx_edges),
        .edge_step(edge_step), .fill_valid(fill_valid), .fill_cycles(fill_cycles),
        .wl_offset(wl_offset), .wl_pf_en(wl_pf_en));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ewma(int a, int s);
        return (s >= a) ? a + ((s - a) >> 3) : a - ((a - s) >> 3);
    endfunction

    function automatic int exp_off();
        int r;
        if (m_mode != 0) return 1;
        r = MAXO;
        for (int k = MAXO; k >= 1; k--) if (longint'(k) * m_vtx >= m_lat) r = k;
        return (r < 2) ? 2 : r;
    endfunction

    always @(posedge clk) begin
        int nmode, nrem;
        if (!rst_n) begin
            m_lat = int'(seed_lat); m_cpe = int'(seed_cpe); m_vtx = int'(seed_vtx);
            m_mode = 0; m_rem = 0; v_cnt = 0; e_cnt = 0; v_have = 0; e_have = 0;
        end else begin
            nmode = m_mode;
            if (vtx_start)
                nmode = (longint'(vtx_edges) * m_cpe > m_lat) ? 1 : 0;
            else if (m_mode == 1 && longint'(m_rem) * m_cpe <= m_lat)
                nmode = 2;
            nrem = vtx_start ? int'(vtx_edges) : ((edge_step && m_rem > 0) ? m_rem - 1 : m_rem);
            if (vtx_start) begin
                if (v_have) m_vtx = ewma(m_vtx, v_cnt);
                v_cnt = 1; v_have = 1;
            end else if (v_cnt < 65535) v_cnt++;
            if (vtx_start) e_have = 0;
            else if (edge_step) begin
                if (e_have) m_cpe = ewma(m_cpe, e_cnt);
                e_cnt = 1; e_have = 1;
            end else if (e_cnt < 65535) e_cnt++;
            if (fill_valid) m_lat = ewma(m_lat, int'(fill_cycles));
            m_mode = nmode; m_rem = nrem;
        end
    end

    task automatic cmp(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic chk(string tag);
        cmp({tag, " offset"}, int'(wl_offset), exp_off());
        cmp({tag, " enable"}, int'(wl_pf_en), (m_mode == 1) ? 0 : 1);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) begin @(negedge clk); chk(tag); end
    endtask

    task automatic vtx(int edges, string tag);
        vtx_start = 1'b1; vtx_edges = EW'(edges);
        @(negedge clk); vtx_start = 1'b0; chk(tag);
    endtask

    task automatic edge1(string tag);
        edge_step = 1'b1;
        @(negedge clk); edge_step = 1'b0; chk(tag);
    endtask

    task automatic fill(int c, string tag);
        fill_valid = 1'b1; fill_cycles = LW'(c);
        @(negedge clk); fill_valid = 1'b0; chk(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: seeded averages and lookahead state after reset
    task automatic t_reset();
        do_reset();
        chk("R1");
        cmp("R1 seeded offset", int'(wl_offset), 5);
        cmp("R1 enable", int'(wl_pf_en), 1);
    endtask

    // R2, R3: latency average steps, offset clamps high and low
    task automatic t_latency();
        do_reset();
        fill(296, "R2");
        cmp("R2 offset after one step", int'(wl_offset), 6);
        for (int i = 0; i < 40; i++) fill(4000, "R3 high");
        cmp("R3 clamp high", int'(wl_offset), 16);
        for (int i = 0; i < 80; i++) fill(1, "R3 low");
        cmp("R3 clamp low", int'(wl_offset), 2);
    endtask

    // R4, R8: vertex gap average with zero-degree vertices
    task automatic t_vertex_gap();
        do_reset();
        for (int i = 0; i < 30; i++) begin
            vtx(0, "R4 R8");
            idle(19, "R4");
        end
        cmp("R4 converged offset", int'(wl_offset), 8);
    endtask

    // R6, R7, R8: large vertex hold, tail release, return to lookahead
    task automatic t_large();
        do_reset();
        vtx(50, "R6");
        cmp("R6 hold enable", int'(wl_pf_en), 0);
        cmp("R6 hold offset", int'(wl_offset), 1);
        for (int i = 0; i < 30; i++) begin
            edge1("R7");
            idle(9, "R7");
        end
        cmp("R7 released enable", int'(wl_pf_en), 1);
        cmp("R7 released offset", int'(wl_offset), 1);
        vtx(3, "R8");
        cmp("R8 back to lookahead", int'(wl_pf_en), 1);
        vtx(40, "R6 again");
        for (int i = 0; i < 45; i++) begin
            edge1("R7 slow edges");
            idle(17, "R7 slow edges");
        end
        vtx(0, "R8 zero degree");
    endtask

    // R5: first edge after a vertex start, and a coincident edge, give no sample
    task automatic t_edge_sample();
        do_reset();
        vtx(1, "R5");
        idle(500, "R5");
        edge1("R5 first edge");
        vtx(20, "R5 no sample");
        cmp("R5 cpe unchanged", int'(wl_pf_en), 1);
        vtx_start = 1'b1; edge_step = 1'b1; vtx_edges = EW'(1);
        @(negedge clk); vtx_start = 1'b0; edge_step = 1'b0; chk("R5 coincident");
        idle(300, "R5");
        edge1("R5 after coincident");
        vtx(20, "R5 coincident ignored");
        cmp("R5 coincident ignored", int'(wl_pf_en), 1);
        edge1("R5 counted");
        idle(499, "R5");
        edge1("R5 sampled");
        vtx(20, "R5 sample taken");
        cmp("R5 sampled cpe holds", int'(wl_pf_en), 0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_vertex_gap();
        t_large();
        t_edge_sample();
        $display(" == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
            $display(" == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule